// File: doc/BRIEF.md
# Mailbox Transmit Priority Arbiter

This block keeps the transmit state for a bank of message mailboxes and decides which one a CAN bit-stream engine sends next. Software programs it through a small word-addressed register port. It sets the enable, direction and interrupt-mask vectors, and a 6-bit priority for each mailbox. It then raises transmit requests with a set-mask write. When the engine is idle, the arbiter grants one eligible mailbox: it presents the mailbox index on `tx_idx` together with a one-cycle `tx_valid` strobe. It holds that grant until the engine reports completion or abort.

A completed send sets the mailbox's acknowledge bit and drops its request in the same edge. If the mailbox's interrupt mask is set, the completion also raises the global mailbox interrupt. Software cancels requests with a reset-mask write. A mailbox that is only waiting is cancelled at once. For the mailbox that is on the wire, the arbiter asks the engine to abort, and the engine's answer decides whether it ends as an abort or as a normal completion.

Register map (word address): 0 enable, 1 direction (1 = receive), 2 request set (reads back pending requests), 3 request reset (reads back the abort being requested of the engine), 4 acknowledge, 5 abort acknowledge, 6 interrupt mask, 7 global flag. Addresses 32+i hold the priority of mailbox i in bits 13:8.

Top module: `mbx_tx_arb`

## Requirements
- R1: After reset every bit vector, every priority, `rd_data`, `tx_valid`, `tx_abort_req` and `irq` read 0.
- R2: A mailbox is granted only if its request, its enable bit (address 0) and a 0 in its direction bit (address 1) are all present. Writing a mask to address 2 sets the request of each mailbox whose bit is 1.
- R3: Among eligible mailboxes the one with the largest priority value wins. On equal priority the highest mailbox number wins.
- R4: While a grant is outstanding there is no further `tx_valid` and `tx_idx` stays stable. A newly pending higher-priority mailbox does not preempt the grant, and clearing the granted mailbox's enable bit does not cancel it.
- R5: On `eng_done` for the granted mailbox, its acknowledge bit (address 4) is set and its request bit is cleared on the same edge. Writing 1 to an acknowledge bit clears it.
- R6: A completion on a mailbox whose mask bit (address 6) is 1 sets `irq`. The global flag register reads bit 15 = flag and bits 4:0 = index of the last mailbox that raised it. Only a write of all ones to address 7 clears the flag. A completion on an unmasked mailbox leaves `irq` unchanged.
- R7: Writing 1 at address 3 for a pending mailbox that is not granted clears its request and sets its abort-acknowledge bit (address 5) on that edge. For a mailbox with no request, the same write changes nothing.
- R8: Writing 1 at address 3 for the granted mailbox raises `tx_abort_req`. An `eng_abort` then sets its abort-acknowledge bit, clears its request, sets no acknowledge bit and no interrupt. An `eng_done` instead completes it as in R5. Either one drops `tx_abort_req`.
- R9: After a grant ends, the next eligible mailbox is granted on the following clock edge.
- R10: Reads return on `rd_data` one cycle after `rd_addr` is presented. A priority word reads back its value in bits 13:8 and zeros elsewhere.
- R11: Writing 1 to an abort-acknowledge bit clears it and leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read word address |
| rd_data | output | 32 | Registered read data |
| tx_valid | output | 1 | One-cycle strobe announcing a new grant |
| tx_idx | output | 5 | Index of the granted mailbox |
| tx_abort_req | output | 1 | Software asks the engine to abort the granted mailbox |
| eng_done | input | 1 | Engine reports the granted frame was sent |
| eng_abort | input | 1 | Engine reports the granted frame was aborted |
| irq | output | 1 | Global mailbox interrupt flag |

## Verification
The bench goes after the ordering corner cases. It includes equal priorities, where a design comparing only the priority field would pick the lower mailbox. It includes the extremes 0 and 63, and high-priority mailboxes set to receive, which a design that ignores the direction bit would wrongly grant. It raises a higher-priority request and clears an enable while a grant is outstanding, which a preempting arbiter would answer with a second strobe. It sends cancellations both to a waiting mailbox and to the one on the wire. A design that routed every cancellation through the engine would leave the waiting request set. A design that let an abort set the acknowledge bit or the interrupt would show up on the readback.

// File: rtl/mbx_arb_pkg.sv
package mbx_arb_pkg;

  // Register select for the low address bits when the top address bit is 0.
  typedef enum logic [2:0] {
    REG_ENA  = 3'd0,
    REG_DIR  = 3'd1,
    REG_SET  = 3'd2,
    REG_RST  = 3'd3,
    REG_ACK  = 3'd4,
    REG_AACK = 3'd5,
    REG_IMSK = 3'd6,
    REG_GFLG = 3'd7
  } reg_sel_e;

  // Priority field position inside a mailbox control word.
  localparam int PRIO_LSB = 8;
  // Flag bit position inside the global flag word.
  localparam int GFLG_BIT = 15;

endpackage

// File: rtl/mbx_prio_file.sv
module mbx_prio_file #(
  parameter int MBX_N  = 32,
  parameter int PRIO_W = 6,
  parameter int IDX_W  = $clog2(MBX_N)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [IDX_W-1:0]          widx,
  input  logic [PRIO_W-1:0]         wprio,
  output logic [MBX_N*PRIO_W-1:0]   prio_flat
);

  logic [PRIO_W-1:0] prio_q [MBX_N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MBX_N; i++) prio_q[i] <= '0;
    end else if (we) begin
      prio_q[widx] <= wprio;
    end
  end

  for (genvar g = 0; g < MBX_N; g++) begin : g_flat
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
  end

endmodule

// File: rtl/mbx_max_tree.sv
module mbx_max_tree #(
  parameter int MBX_N  = 32,
  parameter int PRIO_W = 6,
  parameter int IDX_W  = $clog2(MBX_N)
) (
  input  logic [MBX_N-1:0]          elig,
  input  logic [MBX_N*PRIO_W-1:0]   prio_flat,
  output logic                      any,
  output logic [IDX_W-1:0]          win_idx
);

  localparam int LEAVES = 1 << IDX_W;
  localparam int NODES  = 2 * LEAVES - 1;
  localparam int KEY_W  = PRIO_W + IDX_W;

  // Heap layout: root at 0, children of j at 2j+1 and 2j+2.
  logic             nv [NODES];
  logic [KEY_W-1:0] nk [NODES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < MBX_N) begin : g_real
      assign nv[LEAVES-1+i] = elig[i];
      assign nk[LEAVES-1+i] = {prio_flat[i*PRIO_W +: PRIO_W], IDX_W'(i)};
    end else begin : g_pad
      assign nv[LEAVES-1+i] = 1'b0;
      assign nk[LEAVES-1+i] = '0;
    end
  end

  // Key = {priority, index}: unique per mailbox, so a plain magnitude
  // compare yields highest priority first, highest index on a tie.
  for (genvar j = 0; j < LEAVES - 1; j++) begin : g_node
    logic take_r;
    assign take_r = nv[2*j+2] && (!nv[2*j+1] || (nk[2*j+2] > nk[2*j+1]));
    assign nv[j]  = nv[2*j+1] | nv[2*j+2];
    assign nk[j]  = take_r ? nk[2*j+2] : nk[2*j+1];
  end

  assign any     = nv[0];
  assign win_idx = nk[0][IDX_W-1:0];

endmodule

// File: rtl/mbx_req_bank.sv
module mbx_req_bank
  import mbx_arb_pkg::*;
#(
  parameter int MBX_N  = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(MBX_N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  reg_sel_e           wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               cur_act,
  input  logic [IDX_W-1:0]   cur_idx,
  input  logic [IDX_W-1:0]   gnt_idx,
  input  logic               fin_done,
  input  logic               fin_abort,
  output logic [MBX_N-1:0]   ena,
  output logic [MBX_N-1:0]   dir,
  output logic [MBX_N-1:0]   pend,
  output logic [MBX_N-1:0]   ack,
  output logic [MBX_N-1:0]   aack,
  output logic [MBX_N-1:0]   imask,
  output logic [MBX_N-1:0]   elig
);

  logic [MBX_N-1:0] wmask, set_m, rst_m, ackc_m, aackc_m;
  logic [MBX_N-1:0] cur_bit, fin_bit, imm_ab;
  logic [MBX_N-1:0] pend_n, ack_n, aack_n;

  assign wmask   = wr_data[MBX_N-1:0];
  assign set_m   = (wr_en && wr_sel == REG_SET)  ? wmask : '0;
  assign rst_m   = (wr_en && wr_sel == REG_RST)  ? wmask : '0;
  assign ackc_m  = (wr_en && wr_sel == REG_ACK)  ? wmask : '0;
  assign aackc_m = (wr_en && wr_sel == REG_AACK) ? wmask : '0;

  // The mailbox granted (or being granted this edge) is aborted through
  // the engine; every other pending one is cancelled right here.
  assign cur_bit = cur_act ? (MBX_N'(1) << cur_idx) : '0;
  assign fin_bit = MBX_N'(1) << gnt_idx;
  assign imm_ab  = rst_m & ~cur_bit & pend;

  always_comb begin
    pend_n = pend & ~imm_ab;
    if (fin_done || fin_abort) pend_n = pend_n & ~fin_bit;
    pend_n = pend_n | set_m;

    ack_n = ack & ~ackc_m;
    if (fin_done) ack_n = ack_n | fin_bit;

    aack_n = (aack & ~aackc_m) | imm_ab;
    if (fin_abort) aack_n = aack_n | fin_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ena   <= '0;
      dir   <= '0;
      imask <= '0;
      pend  <= '0;
      ack   <= '0;
      aack  <= '0;
    end else begin
      if (wr_en && wr_sel == REG_ENA)  ena   <= wmask;
      if (wr_en && wr_sel == REG_DIR)  dir   <= wmask;
      if (wr_en && wr_sel == REG_IMSK) imask <= wmask;
      pend <= pend_n;
      ack  <= ack_n;
      aack <= aack_n;
    end
  end

  assign elig = pend & ena & ~dir;

endmodule

// File: rtl/mbx_tx_arb.sv
module mbx_tx_arb
  import mbx_arb_pkg::*;
#(
  parameter int MBX_N  = 32,
  parameter int PRIO_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [$clog2(MBX_N):0]      wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [$clog2(MBX_N):0]      rd_addr,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        tx_valid,
  output logic [$clog2(MBX_N)-1:0]    tx_idx,
  output logic                        tx_abort_req,
  input  logic                        eng_done,
  input  logic                        eng_abort,
  output logic                        irq
);

  localparam int IDX_W  = $clog2(MBX_N);
  localparam int ADDR_W = IDX_W + 1;

  logic                    wr_prio, wr_reg;
  reg_sel_e                wsel, rsel;
  logic [MBX_N*PRIO_W-1:0] prio_flat;
  logic [MBX_N-1:0]        ena, dir, pend, ack, aack, imask, elig;
  logic                    any_elig;
  logic [IDX_W-1:0]        win_idx;

  logic                    busy_q, valid_q, abt_q, gflag_q;
  logic [IDX_W-1:0]        gnt_q, gidx_q;
  logic [DATA_W-1:0]       rd_q;

  logic                    grant_now, cur_act, fin_done, fin_abort, rst_hit, gclr;
  logic [IDX_W-1:0]        cur_idx;

  assign wr_prio = wr_en &  wr_addr[ADDR_W-1];
  assign wr_reg  = wr_en & ~wr_addr[ADDR_W-1];
  assign wsel    = reg_sel_e'(wr_addr[2:0]);
  assign rsel    = reg_sel_e'(rd_addr[2:0]);

  mbx_prio_file #(.MBX_N(MBX_N), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_prio (
    .clk       (clk),
    .rst       (rst),
    .we        (wr_prio),
    .widx      (wr_addr[IDX_W-1:0]),
    .wprio     (wr_data[PRIO_LSB +: PRIO_W]),
    .prio_flat (prio_flat)
  );

  mbx_req_bank #(.MBX_N(MBX_N), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_reg),
    .wr_sel    (wsel),
    .wr_data   (wr_data),
    .cur_act   (cur_act),
    .cur_idx   (cur_idx),
    .gnt_idx   (gnt_q),
    .fin_done  (fin_done),
    .fin_abort (fin_abort),
    .ena       (ena),
    .dir       (dir),
    .pend      (pend),
    .ack       (ack),
    .aack      (aack),
    .imask     (imask),
    .elig      (elig)
  );

  mbx_max_tree #(.MBX_N(MBX_N), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_tree (
    .elig      (elig),
    .prio_flat (prio_flat),
    .any       (any_elig),
    .win_idx   (win_idx)
  );

  // Arbitration only runs while no grant is outstanding.
  assign grant_now = !busy_q && any_elig;
  assign cur_act   = busy_q || any_elig;
  assign cur_idx   = busy_q ? gnt_q : win_idx;
  assign fin_done  = busy_q && eng_done;
  assign fin_abort = busy_q && eng_abort && !eng_done;
  assign rst_hit   = wr_reg && wsel == REG_RST && cur_act && wr_data[cur_idx];
  assign gclr      = wr_reg && wsel == REG_GFLG && (&wr_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      gnt_q   <= '0;
      abt_q   <= 1'b0;
      gflag_q <= 1'b0;
      gidx_q  <= '0;
    end else begin
      valid_q <= grant_now;
      if (grant_now) begin
        busy_q <= 1'b1;
        gnt_q  <= win_idx;
      end else if (fin_done || fin_abort) begin
        busy_q <= 1'b0;
      end

      if (fin_done || fin_abort) abt_q <= 1'b0;
      else if (rst_hit)          abt_q <= 1'b1;

      if (fin_done && imask[gnt_q]) begin
        gflag_q <= 1'b1;
        gidx_q  <= gnt_q;
      end else if (gclr) begin
        gflag_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_addr[ADDR_W-1]) begin
      rd_q <= DATA_W'(prio_flat[rd_addr[IDX_W-1:0]*PRIO_W +: PRIO_W]) << PRIO_LSB;
    end else begin
      unique case (rsel)
        REG_ENA:  rd_q <= DATA_W'(ena);
        REG_DIR:  rd_q <= DATA_W'(dir);
        REG_SET:  rd_q <= DATA_W'(pend);
        REG_RST:  rd_q <= abt_q ? (DATA_W'(1) << gnt_q) : '0;
        REG_ACK:  rd_q <= DATA_W'(ack);
        REG_AACK: rd_q <= DATA_W'(aack);
        REG_IMSK: rd_q <= DATA_W'(imask);
        REG_GFLG: rd_q <= (DATA_W'(gflag_q) << GFLG_BIT) | DATA_W'(gidx_q);
        default:  rd_q <= '0;
      endcase
    end
  end

  assign rd_data      = rd_q;
  assign tx_valid     = valid_q;
  assign tx_idx       = gnt_q;
  assign tx_abort_req = abt_q;
  assign irq          = gflag_q;

endmodule

// File: rtl/mbx_tx_arb_chk.sv
module mbx_tx_arb_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_valid,
  input logic [IDX_W-1:0] tx_idx,
  input logic             tx_abort_req,
  input logic             eng_done,
  input logic             eng_abort,
  input logic             irq
);

  // Independent model of an outstanding grant, seen only at the ports.
  logic held;
  always_ff @(posedge clk) begin
    if (rst)                                             held <= 1'b0;
    else if ((eng_done || eng_abort) && (held || tx_valid)) held <= 1'b0;
    else if (tx_valid)                                   held <= 1'b1;
  end

  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
    ((held || tx_valid) && !eng_done && !eng_abort) |=> !tx_valid); // R4

  AST_IDX_HELD: assert property (@(posedge clk) disable iff (rst)
    ((held || tx_valid) && !eng_done && !eng_abort) |=> $stable(tx_idx)); // R4

  AST_ABORT_REQ_GRANTED: assert property (@(posedge clk) disable iff (rst)
    tx_abort_req |-> (held || tx_valid)); // R8

  AST_IRQ_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(eng_done)); // R6

  AST_ABORT_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (eng_abort && !eng_done && !irq) |=> !irq); // R8

endmodule

bind mbx_tx_arb mbx_tx_arb_chk #(.IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tx_valid     (tx_valid),
  .tx_idx       (tx_idx),
  .tx_abort_req (tx_abort_req),
  .eng_done     (eng_done),
  .eng_abort    (eng_abort),
  .irq          (irq)
);

// File: tb/mbx_tx_arb_test.sv
module mbx_tx_arb_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        tx_valid;
  logic [4:0]  tx_idx;
  logic        tx_abort_req;
  logic        eng_done = 1'b0;
  logic        eng_abort = 1'b0;
  logic        irq;

  int errs = 0;
  int checks = 0;
  int pulses = 0;
  logic [4:0] last_idx = '0;

  always #2.5 clk = ~clk;

  mbx_tx_arb uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tx_valid(tx_valid), .tx_idx(tx_idx),
    .tx_abort_req(tx_abort_req), .eng_done(eng_done), .eng_abort(eng_abort),
    .irq(irq)
  );

  always @(negedge clk) if (!rst && tx_valid) begin
    pulses   <= pulses + 1;
    last_idx <= tx_idx;
  end

  localparam logic [5:0] A_ENA = 6'd0, A_DIR = 6'd1, A_SET = 6'd2, A_RST = 6'd3,
                         A_ACK = 6'd4, A_AACK = 6'd5, A_IMSK = 6'd6, A_GFLG = 6'd7;

  // {rx slots[3:0], expected winner, 4 x {index, priority}}
  localparam logic [52:0] VEC [6] = '{
    {4'b0001, 5'd7,  5'd3, 6'd10, 5'd7,  6'd10, 5'd20, 6'd5,  5'd1,  6'd63},
    {4'b0000, 5'd31, 5'd0, 6'd0,  5'd31, 6'd0,  5'd15, 6'd0,  5'd2,  6'd0},
    {4'b0000, 5'd5,  5'd5, 6'd63, 5'd30, 6'd62, 5'd31, 6'd1,  5'd4,  6'd63},
    {4'b0010, 5'd10, 5'd10,6'd33, 5'd11, 6'd32, 5'd12, 6'd33, 5'd9,  6'd33},
    {4'b0000, 5'd0,  5'd0, 6'd1,  5'd1,  6'd0,  5'd2,  6'd0,  5'd3,  6'd0},
    {4'b0111, 5'd17, 5'd17,6'd2,  5'd18, 6'd50, 5'd19, 6'd50, 5'd16, 6'd50}
  };

  function automatic logic [31:0] bit_of(input int i);
    return 32'(1) << i;
  endfunction

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    rd_addr = a;
    step();
    v = rd_data;
  endtask

  task automatic done_pulse();
    eng_done = 1'b1; step(); eng_done = 1'b0;
  endtask

  task automatic abort_pulse();
    eng_abort = 1'b1; step(); eng_abort = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL WDOG run hung actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int p;
    repeat (3) step();
    rst = 1'b0;
    step();

    // R1: reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 tx_valid", 32'(tx_valid), 0);
    chk("R1 abort_req", 32'(tx_abort_req), 0);
    for (int a = 0; a < 8; a++) begin
      rd(6'(a), v);
      chk("R1 reg", v, 0);
    end
    rd(6'd32 + 6'd31, v);
    chk("R1 prio", v, 0);

    // Table-driven arbitration cases: R2, R3, R5
    for (int c = 0; c < 6; c++) begin
      logic [52:0] e;
      logic [31:0] setm, dirm;
      logic [4:0]  ex;
      e = VEC[c];
      ex = e[48:44];
      setm = '0; dirm = '0;
      wr(A_ENA, 32'h0);
      for (int k = 0; k < 4; k++) begin
        wr(6'd32 + {1'b0, e[43-11*k -: 5]}, 32'(e[38-11*k -: 6]) << 8);
        setm = setm | bit_of(e[43-11*k -: 5]);
        if (e[52-k]) dirm = dirm | bit_of(e[43-11*k -: 5]);
      end
      wr(A_DIR, dirm);
      p = pulses;
      wr(A_SET, setm);
      step();
      chk("R2 no grant while disabled", 32'(pulses), 32'(p));
      wr(A_ENA, 32'hFFFF_FFFF);
      step();
      chk("R2 one grant", 32'(pulses), 32'(p + 1));
      chk("R3 winner", 32'(last_idx), 32'(ex));
      wr(A_ENA, 32'h0);
      done_pulse();
      rd(A_ACK, v);
      chk("R5 ack set", v, bit_of(ex));
      rd(A_SET, v);
      chk("R5 request cleared", v, setm & ~bit_of(ex));
      chk("R6 unmasked no irq", 32'(irq), 0);
      wr(A_RST, 32'hFFFF_FFFF);
      wr(A_ACK, 32'hFFFF_FFFF);
      wr(A_AACK, 32'hFFFF_FFFF);
    end

    // R4, R9: no preemption, enable clear, back-to-back grant
    wr(A_DIR, 32'h0);
    wr(6'd32 + 6'd2, 32'(1) << 8);
    wr(6'd32 + 6'd9, 32'(63) << 8);
    wr(A_ENA, 32'hFFFF_FFFF);
    p = pulses;
    wr(A_SET, bit_of(2));
    step();
    chk("R4 first grant idx", 32'(last_idx), 2);
    wr(A_SET, bit_of(9));
    repeat (4) step();
    chk("R4 no preempt pulses", 32'(pulses), 32'(p + 1));
    chk("R4 idx held", 32'(tx_idx), 2);
    wr(A_ENA, ~bit_of(2));
    step();
    chk("R4 enable clear keeps grant", 32'(tx_idx), 2);
    chk("R4 enable clear no pulse", 32'(pulses), 32'(p + 1));
    wr(A_IMSK, bit_of(9));
    done_pulse();
    chk("R9 not yet regranted", 32'(pulses), 32'(p + 1));
    step();
    chk("R9 regrant next edge", 32'(pulses), 32'(p + 2));
    chk("R9 regrant idx", 32'(last_idx), 9);
    chk("R6 unmasked done no irq", 32'(irq), 0);
    rd(6'd32 + 6'd9, v);
    chk("R10 prio readback", v, 32'h0000_3F00);

    // R6: interrupt flag
    done_pulse();
    chk("R6 irq set", 32'(irq), 1);
    rd(A_GFLG, v);
    chk("R6 flag word", v, 32'h0000_8009);
    wr(A_GFLG, 32'h0000_0001);
    chk("R6 partial write keeps flag", 32'(irq), 1);
    wr(A_GFLG, 32'hFFFF_FFFF);
    chk("R6 all ones clears", 32'(irq), 0);
    rd(A_ACK, v);
    chk("R5 both acks", v, bit_of(2) | bit_of(9));
    wr(A_ACK, bit_of(2));
    rd(A_ACK, v);
    chk("R5 w1c ack", v, bit_of(9));
    wr(A_ACK, 32'hFFFF_FFFF);

    // R7, R8: aborts
    wr(A_ENA, 32'hFFFF_FFFF);
    wr(A_IMSK, bit_of(4) | bit_of(6));
    wr(6'd32 + 6'd4, 32'(40) << 8);
    wr(6'd32 + 6'd6, 32'(20) << 8);
    wr(A_SET, bit_of(4) | bit_of(6));
    step();
    chk("R3 abort setup winner", 32'(last_idx), 4);
    wr(A_RST, bit_of(6));
    chk("R7 no engine abort", 32'(tx_abort_req), 0);
    rd(A_SET, v);
    chk("R7 waiting request dropped", v, bit_of(4));
    rd(A_AACK, v);
    chk("R7 abort ack", v, bit_of(6));
    wr(A_RST, bit_of(20));
    rd(A_AACK, v);
    chk("R7 idle mailbox no effect", v, bit_of(6));
    wr(A_RST, bit_of(4));
    chk("R8 abort request raised", 32'(tx_abort_req), 1);
    rd(A_RST, v);
    chk("R8 abort request readback", v, bit_of(4));
    abort_pulse();
    chk("R8 abort request dropped", 32'(tx_abort_req), 0);
    chk("R8 no irq on abort", 32'(irq), 0);
    rd(A_AACK, v);
    chk("R8 abort ack", v, bit_of(4) | bit_of(6));
    rd(A_ACK, v);
    chk("R8 no ack on abort", v, 0);
    rd(A_SET, v);
    chk("R8 request cleared", v, 0);
    wr(A_AACK, bit_of(6));
    rd(A_AACK, v);
    chk("R11 w1c abort ack", v, bit_of(4));

    p = pulses;
    wr(A_SET, bit_of(6));
    step();
    chk("R8 late grant", 32'(last_idx), 6);
    wr(A_RST, bit_of(6));
    chk("R8 abort asked", 32'(tx_abort_req), 1);
    done_pulse();
    chk("R8 done wins drops request", 32'(tx_abort_req), 0);
    rd(A_ACK, v);
    chk("R8 done wins ack", v, bit_of(6));
    rd(A_AACK, v);
    chk("R8 done wins no abort ack", v, bit_of(4));
    chk("R6 irq after done", 32'(irq), 1);

    finish_run();
  end

endmodule